// File: doc/BRIEF.md
# Validated Key-Matrix Scanner

This block walks a square grid of key switches one intersection at a time. A column counter and a row counter together name the position under test. Exactly one column line is driven, and the row index tells the sense front end which row to listen on. A single digital sense bit comes back for that intersection. Both counters move on a clock-enable tick: the row counter steps every tick, and the column counter steps each time the row counter wraps back to zero. One full matrix pass therefore takes 256 ticks at the default size.

A sequence detector watches the sense bit. It accepts a closure only when the same position reads closed on consecutive passes. It then follows that single key until the key has gone. While it does so it ignores every other position. A threshold-control output tells the sense front end which comparator level to use: a high-immunity level when no validated key is held, and a lowered level while one is held. When a key is accepted, its code is loaded into an output latch: the column in the upper nibble and the row in the lower nibble. A ready flag is raised at the same time, and the consumer clears it with a one-cycle acknowledge.

Top module: `kbd_matrix_scanner`

## Requirements
- R1: While reset is high and in the cycle after it, the block shows this state: `col_drive` = 0x0001, `row_sel` = 0, `thresh_low` = 0, `key_ready` = 0 and `key_code` = 0x00.
- R2: Exactly one bit of `col_drive` is high at all times outside reset.
- R3: Each cycle with `scan_tick` high advances `row_sel` by one, and the value wraps from 15 to 0. With `scan_tick` low, both counters hold their values.
- R4: The driven column advances by one exactly when `row_sel` wraps from 15 to 0, and it wraps from column 15 to column 0.
- R5: A position is accepted only when it reads closed on two consecutive visits, one full pass apart. A closure seen on a single visit never loads the latch.
- R6: The latched code holds the column index in bits 7:4 and the row index in bits 3:0.
- R7: `thresh_low` is 0 (high-immunity level) whenever no accepted key is held. It goes to 1 on the same edge that loads the latch, and it returns to 0 after the first visit on which the held key reads open.
- R8: A key that stays held is never loaded again. After it has read open on one visit, pressing it again is accepted anew by the rule of R5.
- R9: While one position is being confirmed or held, closures at all other positions have no effect. Once the held key is released, such a closure is accepted by the rule of R5.
- R10: A load sets `key_ready`. A `key_ack` pulse with no load clears it. When a load and `key_ack` fall in the same cycle, `key_ready` stays 1 and `key_code` shows the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_tick | input | 1 | Clock enable for the scan counters and the detector |
| sense_in | input | 1 | Closure indication for the intersection currently addressed |
| key_ack | input | 1 | One-cycle acknowledge; clears the ready flag |
| col_drive | output | 16 | One-hot column drive |
| row_sel | output | 4 | Row currently addressed |
| thresh_low | output | 1 | 1 selects the lowered sense threshold, 0 the high-immunity level |
| key_code | output | 8 | Latched code, column in bits 7:4 and row in bits 3:0 |
| key_ready | output | 1 | A latched code is waiting to be acknowledged |

## Verification
The acknowledge of the consumer and the load of a newly confirmed key can hit the latch on the same edge. The bench provokes this by counting visits to a pressed position and raising `key_ack` on exactly the second visit, which is the cycle that loads the latch. It judges the result by requiring `key_ready` to stay set and the code to change to the new key, and then by showing that a lone acknowledge still clears the flag. A second collision is also tested: a rival key is pressed while another key is held. The rival must leave the latch untouched until the first key is released.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

   typedef enum logic [1:0] {
      DET_IDLE    = 2'd0,
      DET_CONFIRM = 2'd1,
      DET_HELD    = 2'd2
   } det_state_e;

endpackage

// File: rtl/kbd_scan_counter.sv
module kbd_scan_counter #(
   parameter int COL_W = 4,
   parameter int ROW_W = 4
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      tick,
   output logic [ROW_W-1:0]          row_o,
   output logic [COL_W-1:0]          col_o,
   output logic [(1 << COL_W)-1:0]   col_onehot_o
);

   localparam int NCOL = 1 << COL_W;
   localparam logic [ROW_W-1:0] ROW_LAST = '1;

   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         row_q <= '0;
         col_q <= '0;
      end else if (tick) begin
         row_q <= row_q + ROW_W'(1);
         if (row_q == ROW_LAST) begin
            col_q <= col_q + COL_W'(1);
         end
      end
   end

   for (genvar gi = 0; gi < NCOL; gi++) begin : g_col_dec
      assign col_onehot_o[gi] = (col_q == COL_W'(gi));
   end

   assign row_o = row_q;
   assign col_o = col_q;

   // R2: a single column line is driven
   p_one_col_r2: assert property (@(posedge clk) disable iff (rst)
      $countones(col_onehot_o) == 1);

   // R3: row steps on tick, holds without it
   p_row_step_r3: assert property (@(posedge clk) disable iff (rst)
      tick |=> row_o == $past(row_o) + ROW_W'(1));
   p_row_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(row_o) && $stable(col_o));

   // R4: column steps only on row wrap
   p_col_wrap_r4: assert property (@(posedge clk) disable iff (rst)
      (tick && row_o == ROW_LAST) |=> col_o == $past(col_o) + COL_W'(1));
   p_col_keep_r4: assert property (@(posedge clk) disable iff (rst)
      (tick && row_o != ROW_LAST) |=> $stable(col_o));

endmodule

// File: rtl/kbd_seq_detector.sv
module kbd_seq_detector
   import kbd_scan_pkg::*;
#(
   parameter int CODE_W         = 8,
   parameter int CONFIRM_PASSES = 2,
   parameter int RELEASE_PASSES = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              sense,
   input  logic [CODE_W-1:0] pos,
   output logic              load_o,
   output logic [CODE_W-1:0] load_code_o,
   output logic              thresh_low_o
);

   localparam int HIT_W  = $clog2(CONFIRM_PASSES + 1);
   localparam int MISS_W = $clog2(RELEASE_PASSES + 1);
   localparam logic [HIT_W-1:0]  HIT_GOAL  = HIT_W'(CONFIRM_PASSES);
   localparam logic [MISS_W-1:0] MISS_GOAL = MISS_W'(RELEASE_PASSES);

   det_state_e        state_q, state_d;
   logic [CODE_W-1:0] cand_q, cand_d;
   logic [HIT_W-1:0]  hits_q, hits_d, hit_inc;
   logic [MISS_W-1:0] miss_q, miss_d, miss_inc;
   logic              at_cand;

   always_comb begin
      state_d  = state_q;
      cand_d   = cand_q;
      hits_d   = hits_q;
      miss_d   = miss_q;
      load_o   = 1'b0;
      at_cand  = (pos == cand_q);
      hit_inc  = (state_q == DET_IDLE) ? HIT_W'(1) : hits_q + HIT_W'(1);
      miss_inc = miss_q + MISS_W'(1);
      if (tick) begin
         case (state_q)
            DET_IDLE: begin
               if (sense) begin
                  cand_d = pos;
                  hits_d = hit_inc;
                  miss_d = '0;
                  if (hit_inc == HIT_GOAL) begin
                     load_o  = 1'b1;
                     state_d = DET_HELD;
                  end else begin
                     state_d = DET_CONFIRM;
                  end
               end
            end
            DET_CONFIRM: begin
               if (at_cand) begin
                  if (sense) begin
                     hits_d = hit_inc;
                     if (hit_inc == HIT_GOAL) begin
                        load_o  = 1'b1;
                        state_d = DET_HELD;
                     end
                  end else begin
                     state_d = DET_IDLE;
                  end
               end
            end
            DET_HELD: begin
               if (at_cand) begin
                  if (sense) begin
                     miss_d = '0;
                  end else if (miss_inc == MISS_GOAL) begin
                     state_d = DET_IDLE;
                  end else begin
                     miss_d = miss_inc;
                  end
               end
            end
            default: state_d = DET_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= DET_IDLE;
         cand_q  <= '0;
         hits_q  <= '0;
         miss_q  <= '0;
      end else begin
         state_q <= state_d;
         cand_q  <= cand_d;
         hits_q  <= hits_d;
         miss_q  <= miss_d;
      end
   end

   assign load_code_o  = pos;
   assign thresh_low_o = (state_q == DET_HELD);

   // R5: acceptance needs a live closure on a tick
   p_load_needs_sense_r5: assert property (@(posedge clk) disable iff (rst)
      load_o |-> (tick && sense));

   // R8: no second load while a key is held
   p_no_reload_r8: assert property (@(posedge clk) disable iff (rst)
      thresh_low_o |-> !load_o);

   // R9: other positions leave the tracked key untouched
   p_ignore_other_r9: assert property (@(posedge clk) disable iff (rst)
      (state_q != DET_IDLE && tick && !at_cand) |=> ($stable(cand_q) && $stable(state_q)));

   // R7: lowered threshold persists until the held key reads open
   p_hold_low_r7: assert property (@(posedge clk) disable iff (rst)
      (thresh_low_o && !(tick && at_cand && !sense)) |=> thresh_low_o);

endmodule

// File: rtl/kbd_code_latch.sv
module kbd_code_latch #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [CODE_W-1:0] code,
   input  logic              ack,
   output logic [CODE_W-1:0] key_code_o,
   output logic              key_ready_o
);

   always_ff @(posedge clk) begin
      if (rst) begin
         key_code_o  <= '0;
         key_ready_o <= 1'b0;
      end else if (load) begin
         key_code_o  <= code;
         key_ready_o <= 1'b1;
      end else if (ack) begin
         key_ready_o <= 1'b0;
      end
   end

   // R10: a load always leaves the flag set with the new code
   p_load_sets_r10: assert property (@(posedge clk) disable iff (rst)
      load |=> (key_ready_o && key_code_o == $past(code)));

   // R10: a lone acknowledge clears the flag
   p_ack_clears_r10: assert property (@(posedge clk) disable iff (rst)
      (ack && !load) |=> !key_ready_o);

endmodule

// File: rtl/kbd_matrix_scanner.sv
module kbd_matrix_scanner #(
   parameter int COL_W          = 4,
   parameter int ROW_W          = 4,
   parameter int CONFIRM_PASSES = 2,
   parameter int RELEASE_PASSES = 1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       scan_tick,
   input  logic                       sense_in,
   input  logic                       key_ack,
   output logic [(1 << COL_W)-1:0]    col_drive,
   output logic [ROW_W-1:0]           row_sel,
   output logic                       thresh_low,
   output logic [COL_W+ROW_W-1:0]     key_code,
   output logic                       key_ready
);

   localparam int CODE_W = COL_W + ROW_W;

   initial begin
      if (COL_W < 1 || COL_W > 6)
         $fatal(1, "kbd_matrix_scanner: COL_W out of range");
      if (ROW_W < 1 || ROW_W > 6)
         $fatal(1, "kbd_matrix_scanner: ROW_W out of range");
      if (CONFIRM_PASSES < 1)
         $fatal(1, "kbd_matrix_scanner: CONFIRM_PASSES must be at least 1");
      if (RELEASE_PASSES < 1)
         $fatal(1, "kbd_matrix_scanner: RELEASE_PASSES must be at least 1");
   end

   logic [COL_W-1:0]  col_idx;
   logic [CODE_W-1:0] load_code;
   logic              load;

   kbd_scan_counter #(
      .COL_W (COL_W),
      .ROW_W (ROW_W)
   ) i_counter (
      .clk          (clk),
      .rst          (rst),
      .tick         (scan_tick),
      .row_o        (row_sel),
      .col_o        (col_idx),
      .col_onehot_o (col_drive)
   );

   kbd_seq_detector #(
      .CODE_W         (CODE_W),
      .CONFIRM_PASSES (CONFIRM_PASSES),
      .RELEASE_PASSES (RELEASE_PASSES)
   ) i_detector (
      .clk          (clk),
      .rst          (rst),
      .tick         (scan_tick),
      .sense        (sense_in),
      .pos          ({col_idx, row_sel}),
      .load_o       (load),
      .load_code_o  (load_code),
      .thresh_low_o (thresh_low)
   );

   kbd_code_latch #(
      .CODE_W (CODE_W)
   ) i_latch (
      .clk         (clk),
      .rst         (rst),
      .load        (load),
      .code        (load_code),
      .ack         (key_ack),
      .key_code_o  (key_code),
      .key_ready_o (key_ready)
   );

   // R7: each fresh code arrives with the lowered threshold selected
   p_ready_low_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(key_ready) |-> thresh_low);

   // R6: the latched upper nibble names the column that was driven
   p_code_col_r6: assert property (@(posedge clk) disable iff (rst)
      load |=> key_code[CODE_W-1:ROW_W] == $past(col_idx));

endmodule

// File: tb/test_kbd_matrix_scanner.sv
module test_kbd_matrix_scanner;

   localparam time CLK_PERIOD = 10ns;
   localparam int  PASS_LEN   = 256;
   localparam int  WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst;
   logic        scan_tick;
   logic        sense_in;
   logic        key_ack;
   logic [15:0] col_drive;
   logic [3:0]  row_sel;
   logic        thresh_low;
   logic [7:0]  key_code;
   logic        key_ready;

   logic [255:0] pressed;
   logic         glitch_on;
   logic [7:0]   cur_pos;
   logic [3:0]   cur_col;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   kbd_matrix_scanner i_kbd_matrix_scanner (
      .clk        (clk),
      .rst        (rst),
      .scan_tick  (scan_tick),
      .sense_in   (sense_in),
      .key_ack    (key_ack),
      .col_drive  (col_drive),
      .row_sel    (row_sel),
      .thresh_low (thresh_low),
      .key_code   (key_code),
      .key_ready  (key_ready)
   );

   // environment: key grid answering the addressed intersection
   always_comb begin
      cur_col = 4'd0;
      for (int i = 0; i < 16; i++) begin
         if (col_drive[i]) cur_col = 4'(i);
      end
      cur_pos  = {cur_col, row_sel};
      sense_in = pressed[cur_pos] | glitch_on;
   end

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WATCHDOG) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
         finish_run();
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_visit(input logic [7:0] p);
      do @(negedge clk); while (cur_pos != p);
   endtask

   task automatic pulse_ack();
      key_ack = 1'b1;
      @(negedge clk);
      key_ack = 1'b0;
   endtask

   localparam logic [7:0] KEY_A  = 8'hA3;
   localparam logic [7:0] KEY_B  = 8'h27;
   localparam logic [7:0] KEY_G  = 8'h5C;

   initial begin
      rst       = 1'b1;
      scan_tick = 1'b1;
      key_ack   = 1'b0;
      pressed   = '0;
      glitch_on = 1'b0;
      repeat (3) @(negedge clk);

      // R1: reset state
      chk("R1 col_drive", 32'(col_drive), 32'h0001);
      chk("R1 row_sel", 32'(row_sel), 32'd0);
      chk("R1 thresh_low", 32'(thresh_low), 32'd0);
      chk("R1 key_ready", 32'(key_ready), 32'd0);
      chk("R1 key_code", 32'(key_code), 32'd0);
      rst = 1'b0;

      // R3 R4 R2: sweep more than two passes, positions computed arithmetically
      for (int k = 1; k <= 2 * PASS_LEN + 8; k++) begin
         @(negedge clk);
         chk("R3 row step", 32'(row_sel), 32'(k % 16));
         chk("R4 col step", 32'(col_drive), 32'(1) << ((k / 16) % 16));
         chk("R2 one column", 32'($countones(col_drive)), 32'd1);
      end
      chk("R7 idle level", 32'(thresh_low), 32'd0);

      // R3: no tick, no movement (position after 520 ticks: row 8, col 0)
      scan_tick = 1'b0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         chk("R3 hold row", 32'(row_sel), 32'd8);
         chk("R3 hold col", 32'(col_drive), 32'h0001);
      end
      scan_tick = 1'b1;

      // R5: single-visit glitch is rejected
      wait_visit(KEY_G);
      glitch_on = 1'b1;
      @(negedge clk);
      glitch_on = 1'b0;
      chk("R7 confirm keeps idle level", 32'(thresh_low), 32'd0);
      wait_visit(KEY_G);
      @(negedge clk);
      repeat (PASS_LEN) @(negedge clk);
      chk("R5 glitch no ready", 32'(key_ready), 32'd0);
      chk("R5 glitch no code", 32'(key_code), 32'd0);
      chk("R7 glitch level", 32'(thresh_low), 32'd0);

      // R5 R6 R7: key A held, accepted on second visit
      pressed[KEY_A] = 1'b1;
      wait_visit(KEY_A);
      wait_visit(KEY_A);
      chk("R5 not before second visit", 32'(key_ready), 32'd0);
      @(negedge clk);
      chk("R5 accepted", 32'(key_ready), 32'd1);
      chk("R6 code A", 32'(key_code), 32'(KEY_A));
      chk("R7 lowered while held", 32'(thresh_low), 32'd1);

      // R10 R8: acknowledge, then held key never reloads
      pulse_ack();
      chk("R10 ack clears", 32'(key_ready), 32'd0);
      repeat (3 * PASS_LEN) @(negedge clk);
      chk("R8 no reload", 32'(key_ready), 32'd0);
      chk("R7 still lowered", 32'(thresh_low), 32'd1);

      // R9: rival key B ignored while A held
      pressed[KEY_B] = 1'b1;
      repeat (3 * PASS_LEN) @(negedge clk);
      chk("R9 rival no ready", 32'(key_ready), 32'd0);
      chk("R9 rival no code", 32'(key_code), 32'(KEY_A));

      // R9 R7: release A, then B is accepted by the two-visit rule
      pressed[KEY_A] = 1'b0;
      wait_visit(KEY_A);
      @(negedge clk);
      chk("R7 back to idle level", 32'(thresh_low), 32'd0);
      wait_visit(KEY_B);
      wait_visit(KEY_B);
      chk("R9 B not early", 32'(key_ready), 32'd0);
      @(negedge clk);
      chk("R9 B accepted", 32'(key_ready), 32'd1);
      chk("R6 code B", 32'(key_code), 32'(KEY_B));

      // R8 R10: release B, press again, ack collides with the load
      pressed[KEY_B] = 1'b0;
      wait_visit(KEY_B);
      @(negedge clk);
      chk("R7 idle after B", 32'(thresh_low), 32'd0);
      pressed[KEY_B] = 1'b1;
      wait_visit(KEY_B);
      wait_visit(KEY_B);
      pulse_ack();
      chk("R10 load beats ack", 32'(key_ready), 32'd1);
      chk("R8 re-press code", 32'(key_code), 32'(KEY_B));
      chk("R8 re-press level", 32'(thresh_low), 32'd1);
      pulse_ack();
      chk("R10 lone ack", 32'(key_ready), 32'd0);

      // R1: reset mid-hold restores reset state
      rst = 1'b1;
      @(negedge clk);
      chk("R1 reset level", 32'(thresh_low), 32'd0);
      chk("R1 reset code", 32'(key_code), 32'd0);
      chk("R1 reset row", 32'(row_sel), 32'd0);
      rst = 1'b0;

      finish_run();
   end

endmodule